// File: doc/BRIEF.md
# NAND Controller Status and Interrupt Register

This block holds the 32-bit status word of a NAND flash controller. It reflects live levels: the flash ready/busy line after a synchronizer, and the two chip-enable outputs that the controller drives. It also keeps a boot-load-done indication and three sticky event flags. The first flag records a ready/busy transition on an edge chosen by a mode input. The second records the end of an ECC decode. The third records a program or erase attempt made while a lock is in force.

Software reads the word through a simple register bus and clears any sticky flag by writing 1 to its bit. Each sticky flag drives a level interrupt, gated by its own enable input. The surrounding engines (ECC, lock, boot copy, command sequencing) only supply pulses and levels to this block.

Top module: `nand_status_reg`

## Requirements
- R1: Out of reset the status word reads 0x0080001D, given that both chip-enable outputs are high. Bits 0, 2, 3, 4 and 23 are 1 and every other bit is 0.
- R2: Bit 0 shows the ready/busy input (1 ready, 0 busy) two clock edges after it changes. Bit 2 shows chip-enable output 0 and bit 3 shows chip-enable output 1, both in the same cycle.
- R3: Bit 4 sets on the third clock edge after a ready/busy transition of the selected kind. With the edge-select input at 0 the block responds to rising transitions, and with it at 1 to falling ones. A transition of the other kind leaves bit 4 unchanged.
- R4: A one-cycle ECC-decode-done pulse sets bit 6 at the next clock edge.
- R5: A program/erase attempt pulse sets bit 5 at the next clock edge only while the lock-active input is 1. With the lock inactive it has no effect.
- R6: A bus write with a 1 in bit 4, 5 or 6 clears that flag at the next edge. A 0 in a sticky bit leaves the flag unchanged.
- R7: When a set event and a write-one-to-clear reach the same flag in the same cycle, the flag ends set.
- R8: Bits 1, 22:7 and 31:24 always read 0. Writes to those bits and to bits 0, 2, 3 and 23 change nothing.
- R9: The interrupt for each flag is a level equal to the flag ANDed with its enable, and it follows the enable in the same cycle.
- R10: Bit 23 follows the boot-done input one clock edge later and is 1 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Write strobe for the status word |
| regWrData | input | 32 | Write data; 1s in bits 4..6 clear flags |
| regRdData | output | 32 | Current status word |
| rnbIn | input | 1 | Flash ready/busy pin (asynchronous) |
| chipEnOut | input | 2 | Levels of chip-enable outputs 1:0 |
| edgeSelFall | input | 1 | 0 selects rising, 1 falling ready/busy edge |
| eccDecodeDone | input | 1 | One-cycle ECC decode completion pulse |
| lockActive | input | 1 | Soft lock or lock-tight in force |
| progEraseReq | input | 1 | One-cycle program/erase attempt pulse |
| bootDoneIn | input | 1 | Boot-area copy finished level |
| irqEnRnb | input | 1 | Enable for transition interrupt |
| irqEnIllegal | input | 1 | Enable for illegal-access interrupt |
| irqEnEcc | input | 1 | Enable for ECC-done interrupt |
| irqRnb | output | 1 | Transition interrupt level |
| irqIllegal | output | 1 | Illegal-access interrupt level |
| irqEcc | output | 1 | ECC-done interrupt level |

## Verification
Each result has a fixed latency. Chip-enable bits and interrupt gating are due in the cycle the input changes. The ECC, illegal-access, write-clear and boot-done results are due one edge later. The ready/busy level bit is due two edges later and the transition flag three edges later. The driver records each expectation with its due cycle, counted from the number of rising edges seen. The monitor compares the word and the interrupts just after that edge settles, and it also checks the intermediate edges, so a flag that comes early fails as well.

// File: rtl/nand_status_pkg.sv
package nand_status_pkg;
  localparam int WORD_W      = 32;
  localparam int RNB_BIT     = 0;
  localparam int CE0_BIT     = 2;
  localparam int CE1_BIT     = 3;
  localparam int EVT_BASE    = 4;   // sticky flags occupy EVT_BASE .. EVT_BASE+NUM_FLAGS-1
  localparam int NUM_FLAGS   = 3;
  localparam int FLAG_RNB    = 0;   // bit 4
  localparam int FLAG_ILL    = 1;   // bit 5
  localparam int FLAG_ECC    = 2;   // bit 6
  localparam int BOOT_BIT    = 23;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setEvt;
    logic [NUM_FLAGS-1:0] clrEvt;
  } statStrobes_t;
endpackage

// File: rtl/nand_status_ctrl.sv
module nand_status_ctrl
  import nand_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rnbIn,
  input  logic              edgeSelFall,
  input  logic              eccDecodeDone,
  input  logic              lockActive,
  input  logic              progEraseReq,
  input  logic              regWrEn,
  input  logic [WORD_W-1:0] regWrData,
  output logic              rnbLevel,
  output statStrobes_t      strb
);
  logic [SYNC_STAGES-1:0] rnbPipe;
  logic                   rnbPrev;
  logic                   riseSeen;
  logic                   fallSeen;
  logic                   unusedWrBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rnbPipe <= '1;
      rnbPrev <= 1'b1;
    end else begin
      rnbPipe <= {rnbPipe[SYNC_STAGES-2:0], rnbIn};
      rnbPrev <= rnbPipe[SYNC_STAGES-1];
    end
  end

  assign rnbLevel = rnbPipe[SYNC_STAGES-1];
  assign riseSeen = rnbLevel & ~rnbPrev;
  assign fallSeen = ~rnbLevel & rnbPrev;

  always_comb begin
    strb = '0;
    strb.setEvt[FLAG_RNB] = edgeSelFall ? fallSeen : riseSeen;
    strb.setEvt[FLAG_ILL] = progEraseReq & lockActive;
    strb.setEvt[FLAG_ECC] = eccDecodeDone;
    for (int i = 0; i < NUM_FLAGS; i++)
      strb.clrEvt[i] = regWrEn & regWrData[EVT_BASE+i];
  end

  assign unusedWrBits = ^{regWrData[WORD_W-1:EVT_BASE+NUM_FLAGS], regWrData[EVT_BASE-1:0]};

  // R5: an illegal-access strobe never leaves without an active lock
  assert_illegal_needs_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEvt[FLAG_ILL] |-> lockActive);
endmodule

// File: rtl/nand_status_dp.sv
module nand_status_dp
  import nand_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  statStrobes_t      strb,
  input  logic              rnbLevel,
  input  logic [1:0]        chipEnOut,
  input  logic              bootDoneIn,
  input  logic [NUM_FLAGS-1:0] irqEn,
  output logic [WORD_W-1:0] statusWord,
  output logic [NUM_FLAGS-1:0] irqVec
);
  logic [NUM_FLAGS-1:0] flagVec;
  logic                 bootReg;

  localparam logic [NUM_FLAGS-1:0] FLAG_RST = NUM_FLAGS'(1) << FLAG_RNB;

  genvar g;
  generate
    for (g = 0; g < NUM_FLAGS; g++) begin : gFlag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 flagVec[g] <= FLAG_RST[g];
        else if (strb.setEvt[g])   flagVec[g] <= 1'b1;
        else if (strb.clrEvt[g])   flagVec[g] <= 1'b0;
      end

      // R7: a set strobe always leaves the flag set
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
        strb.setEvt[g] |=> flagVec[g]);
      // R6: a lone clear strobe empties the flag
      assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
        (strb.clrEvt[g] && !strb.setEvt[g]) |=> !flagVec[g]);
      // R6: without strobes the flag keeps its value
      assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
        (!strb.clrEvt[g] && !strb.setEvt[g]) |=> $stable(flagVec[g]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootReg <= 1'b1;
    else       bootReg <= bootDoneIn;
  end

  always_comb begin
    statusWord = '0;
    statusWord[RNB_BIT]  = rnbLevel;
    statusWord[CE0_BIT]  = chipEnOut[0];
    statusWord[CE1_BIT]  = chipEnOut[1];
    statusWord[EVT_BASE +: NUM_FLAGS] = flagVec;
    statusWord[BOOT_BIT] = bootReg;
  end

  assign irqVec = flagVec & irqEn;

  // R10: boot-done bit tracks its input one edge later
  assert_boot_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    bootDoneIn |=> statusWord[BOOT_BIT]);
endmodule

// File: rtl/nand_status_reg.sv
module nand_status_reg
  import nand_status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        rnbIn,
  input  logic [1:0]  chipEnOut,
  input  logic        edgeSelFall,
  input  logic        eccDecodeDone,
  input  logic        lockActive,
  input  logic        progEraseReq,
  input  logic        bootDoneIn,
  input  logic        irqEnRnb,
  input  logic        irqEnIllegal,
  input  logic        irqEnEcc,
  output logic        irqRnb,
  output logic        irqIllegal,
  output logic        irqEcc
);
  statStrobes_t         strb;
  logic                 rnbLevel;
  logic [NUM_FLAGS-1:0] irqEn;
  logic [NUM_FLAGS-1:0] irqVec;

  always_comb begin
    irqEn = '0;
    irqEn[FLAG_RNB] = irqEnRnb;
    irqEn[FLAG_ILL] = irqEnIllegal;
    irqEn[FLAG_ECC] = irqEnEcc;
  end

  nand_status_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .rnbIn(rnbIn), .edgeSelFall(edgeSelFall),
    .eccDecodeDone(eccDecodeDone), .lockActive(lockActive),
    .progEraseReq(progEraseReq), .regWrEn(regWrEn), .regWrData(regWrData),
    .rnbLevel(rnbLevel), .strb(strb)
  );

  nand_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rnbLevel(rnbLevel),
    .chipEnOut(chipEnOut), .bootDoneIn(bootDoneIn), .irqEn(irqEn),
    .statusWord(regRdData), .irqVec(irqVec)
  );

  assign irqRnb     = irqVec[FLAG_RNB];
  assign irqIllegal = irqVec[FLAG_ILL];
  assign irqEcc     = irqVec[FLAG_ECC];

  // R9: a disabled interrupt never asserts
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEnEcc |-> !irqEcc) and (!irqEnRnb |-> !irqRnb) and (!irqEnIllegal |-> !irqIllegal));
endmodule

// File: tb/nand_status_reg_bench.sv
module nand_status_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rnbIn = 1'b1;
  logic [1:0]  chipEnOut = 2'b11;
  logic        edgeSelFall = 1'b0;
  logic        eccDecodeDone = 1'b0;
  logic        lockActive = 1'b0;
  logic        progEraseReq = 1'b0;
  logic        bootDoneIn = 1'b1;
  logic        irqEnRnb = 1'b0;
  logic        irqEnIllegal = 1'b0;
  logic        irqEnEcc = 1'b0;
  logic        irqRnb, irqIllegal, irqEcc;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_status_reg u_nand_status_reg (.*);

  typedef struct {
    int          due;
    logic [31:0] mask;
    logic [31:0] exp;
    logic [2:0]  irqExp;   // {illegal, ecc, rnb}
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic expectAt(input int n, input logic [31:0] mask, input logic [31:0] exp,
                          input logic [2:0] irqExp, input string req);
    expItem_t it;
    it.due = cyc + n; it.mask = mask; it.exp = exp; it.irqExp = irqExp; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [31:0] data);
    regWrEn = 1'b1; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  // monitor: compare due items just after each rising edge settles
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      for (int i = expQ.size() - 1; i >= 0; i--) begin
        if (expQ[i].due == cyc) begin
          logic [2:0] irqAct;
          irqAct = {irqIllegal, irqEcc, irqRnb};
          checks++;
          if (((regRdData & expQ[i].mask) != expQ[i].exp) || (irqAct != expQ[i].irqExp)) begin
            fails++;
            $display("FAIL %s: word&mask=%h irq=%b expected word=%h irq=%b",
                     expQ[i].req, regRdData & expQ[i].mask, irqAct, expQ[i].exp, expQ[i].irqExp);
          end
          expQ.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    expectAt(1, 32'hFFFF_FFFF, 32'h0080_001D, 3'b000, "R1 reset image");
    step(2);

    // R8 / R6: writes to reserved, read-only bits and 0s into sticky bits change nothing
    expectAt(1, 32'hFFFF_FFFF, 32'h0080_001D, 3'b000, "R8 ignored write");
    expectAt(1, 32'h0000_0070, 32'h0000_0010, 3'b000, "R6 zero write keeps flag");
    regWrite(32'hFF8F_FF8F);
    expectAt(1, 32'h0000_0010, 32'h0, 3'b000, "R6 clear transition flag");
    regWrite(32'h0000_0010);
    irqEnRnb = 1'b1;
    step(1);

    // R2 / R3: falling ready/busy in rising mode
    rnbIn = 1'b0;
    expectAt(1, 32'h1, 32'h1, 3'b000, "R2 level not yet synced");
    expectAt(2, 32'h11, 32'h0, 3'b000, "R2 busy level");
    expectAt(3, 32'h10, 32'h0, 3'b000, "R3 opposite edge ignored");
    step(4);

    // R3 / R9: rising edge sets flag on third edge, interrupt enabled
    rnbIn = 1'b1;
    expectAt(2, 32'h11, 32'h01, 3'b000, "R3 flag not early");
    expectAt(3, 32'h11, 32'h11, 3'b001, "R3 rising edge flag");
    step(4);
    irqEnRnb = 1'b0;
    expectAt(1, 32'h10, 32'h10, 3'b000, "R9 enable gates irq");
    step(1);
    expectAt(1, 32'h10, 32'h0, 3'b000, "R6 clear after rise");
    regWrite(32'h0000_0010);

    // R3: falling mode
    edgeSelFall = 1'b1;
    rnbIn = 1'b0;
    expectAt(3, 32'h11, 32'h10, 3'b000, "R3 falling edge flag");
    step(4);
    regWrite(32'h0000_0010);
    rnbIn = 1'b1;
    expectAt(3, 32'h11, 32'h01, 3'b000, "R3 rising ignored in fall mode");
    step(4);
    edgeSelFall = 1'b0;

    // R4 / R9: ECC completion
    irqEnEcc = 1'b1;
    eccDecodeDone = 1'b1;
    expectAt(1, 32'h40, 32'h40, 3'b010, "R4 ecc flag and irq");
    step(1);
    eccDecodeDone = 1'b0;
    step(1);

    // R7: set and clear together
    eccDecodeDone = 1'b1;
    expectAt(1, 32'h40, 32'h40, 3'b010, "R7 set wins over clear");
    regWrite(32'h0000_0040);
    eccDecodeDone = 1'b0;
    expectAt(1, 32'h40, 32'h0, 3'b000, "R6 clear ecc flag");
    regWrite(32'h0000_0040);

    // R5: illegal access only under lock
    irqEnIllegal = 1'b1;
    progEraseReq = 1'b1;
    expectAt(1, 32'h20, 32'h0, 3'b000, "R5 unlocked attempt ignored");
    step(1);
    progEraseReq = 1'b0;
    lockActive = 1'b1;
    step(1);
    progEraseReq = 1'b1;
    expectAt(1, 32'h20, 32'h20, 3'b100, "R5 locked attempt flagged");
    step(1);
    progEraseReq = 1'b0;
    lockActive = 1'b0;
    expectAt(1, 32'h20, 32'h0, 3'b000, "R6 clear illegal flag");
    regWrite(32'h0000_0020);

    // R2: chip-enable levels
    chipEnOut = 2'b01;
    expectAt(1, 32'hC, 32'h4, 3'b000, "R2 ce0 level");
    step(1);
    chipEnOut = 2'b10;
    expectAt(1, 32'hC, 32'h8, 3'b000, "R2 ce1 level");
    step(1);
    chipEnOut = 2'b11;

    // R10: boot-done follows input
    bootDoneIn = 1'b0;
    expectAt(1, 32'h0080_0000, 32'h0, 3'b000, "R10 boot done low");
    step(1);
    bootDoneIn = 1'b1;
    expectAt(1, 32'h0080_0000, 32'h0080_0000, 3'b000, "R10 boot done high");
    step(2);

    expectAt(1, 32'hFFFF_FFFF, 32'h0080_000D, 3'b000, "R8 reserved bits zero");
    step(3);

    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL queue drain: pending=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule